// File: doc/BRIEF.md
# Endpoint Configuration Register Space

This block is the configuration register file of an endpoint function on a PCI-style bus. It decodes a space of 1024 dword registers, of which only a sparse set is backed by storage: identity words, the command word, the cache-line byte, six base address registers, the expansion-ROM base and the interrupt word. Every backed register carries a writable mask. A write changes only those bits that the mask allows and that fall inside the lanes being addressed. Every other index reads as zero and ignores writes.

The identity fields and the base address register layout come in as configuration inputs. The identity words are captured while reset is held. The base address layout is read continuously and must be held steady. A bus front end outside this block issues byte, word or dword writes and dword reads. Software sizes each region by writing all ones to its base register and reading back the size pattern. A separate strobe installs the interrupt line and pin on behalf of the platform.

Top module: `pcfg_space`

## Requirements
- R1: A read with `rd_idx` of 1024 or more returns 0xFFFFFFFF. A write with `wr_idx` of 1024 or more changes nothing. In-range indices with no backing storage read 0 and ignore writes.
- R2: While `rst_n` is low, the block captures the identity words. Index 0 is {device, vendor}. Index 2 is {class, subclass, prog-if, revision}, from bit 31 down. Index 11 is {subsystem, subsystem vendor}. All three are read-only, and input changes after reset do not affect them.
- R3: Index 1 resets to 0 and has bits 15:0 writable, with bits 31:16 read-only zero. Index 3 has only bits 7:0 writable. Index 15 has only bits 7:0 writable by bus writes.
- R4: Base registers occupy indices 4 to 9. `bar_kind` per slot is coded 0 none, 1 I/O, 2 32-bit memory, 3 64-bit memory. Memory slots have address mask 0xFFFFFFF0 and read-only type bits: bit 2 is set for 64-bit and bit 3 for prefetchable. I/O slots have mask 0xFFFFFFFC and type value 1. A slot of kind none reads 0 and ignores writes.
- R5: A dword write of exactly 0xFFFFFFFF to a base register narrows its mask by the size pattern ~(2^L − 1). The next read returns that pattern with the type bits. Any other write stores the masked address.
- R6: A 64-bit slot makes the next slot its upper half, whatever that slot's own kind. The upper half is fully writable and returns the upper 32 bits of the 64-bit size pattern when probed. A 64-bit kind in the last slot acts as none.
- R7: Index 12 is the ROM base, with mask 0xFFFFF800 when `rom_en` is set and 0 otherwise. A dword write with bits 31:11 all ones is narrowed by ~(2^`rom_size_log2` − 1).
- R8: `wr_size` is coded 0 byte, 1 word, 2 dword, 3 reserved. A word write at an odd byte offset, a dword write at a non-zero offset, and a reserved size all change nothing.
- R9: Byte and word data sit right-justified in `wr_data` and land in the lane chosen by `wr_off`. Only addressed bits that are also writable change. A partial write of all ones never triggers size probing.
- R10: A pulse on `irq_set` writes {`irq_pin`+1, `irq_line`} into bits 15:0 of index 15 and keeps bits 31:16. It takes priority over a bus write in the same cycle.
- R11: A write takes effect at the clock edge that samples it. `rd_data` follows `rd_idx` and the stored state without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_vendor | input | 16 | Vendor identifier, captured in reset |
| id_device | input | 16 | Device identifier, captured in reset |
| id_revision | input | 8 | Revision, captured in reset |
| id_progif | input | 8 | Programming interface, captured in reset |
| id_subclass | input | 8 | Subclass, captured in reset |
| id_class | input | 8 | Class, captured in reset |
| id_subsys_vendor | input | 16 | Subsystem vendor, captured in reset |
| id_subsys | input | 16 | Subsystem identifier, captured in reset |
| bar_kind | input | 2*NUM_BARS | Per-slot kind (0 none, 1 I/O, 2 mem32, 3 mem64) |
| bar_pref | input | NUM_BARS | Per-slot prefetchable flag |
| bar_size_log2 | input | 6*NUM_BARS | Per-slot log2 of region size |
| rom_en | input | 1 | ROM base register present |
| rom_size_log2 | input | 5 | log2 of ROM size |
| irq_set | input | 1 | Install interrupt line and pin |
| irq_line | input | 8 | Interrupt line value |
| irq_pin | input | 2 | Interrupt pin, 0-based |
| wr_en | input | 1 | Write request |
| wr_size | input | 2 | Access size code |
| wr_idx | input | IDX_W | Dword index of the write |
| wr_off | input | 2 | Byte offset within the dword |
| wr_data | input | 32 | Right-justified write data |
| rd_idx | input | IDX_W | Dword index of the read |
| rd_data | output | 32 | Read data |

## Verification
A corrupted writable mask shows at the port on the first read after any write to that register. Either a read-only bit changes, or an address bit that should hold does not. A wrong size pattern or lost type bits appear on the first read after a probe or a reset. A wrong slot role, such as an upper half that is not recognised, shows at once as a nonzero read of a slot that should be absent, or as a zero where a type field belongs. Lane-selection faults show on the next read as changes outside the addressed byte or word. An index that wraps silently corrupts a low register, which the next read of that register reveals.

// File: rtl/pcfg_pkg.sv
// Shared types and helpers for the configuration register space.
// Assumes dword-organised registers of 32 bits.
package pcfg_pkg;

    localparam int unsigned IDX_IDENT  = 0;
    localparam int unsigned IDX_CMD    = 1;
    localparam int unsigned IDX_CLASS  = 2;
    localparam int unsigned IDX_MISC   = 3;
    localparam int unsigned IDX_BAR0   = 4;
    localparam int unsigned IDX_SUBSYS = 11;
    localparam int unsigned IDX_ROM    = 12;
    localparam int unsigned IDX_IRQ    = 15;

    localparam logic [31:0] CMD_WMASK  = 32'h0000_FFFF;
    localparam logic [31:0] BYTE_WMASK = 32'h0000_00FF;
    localparam logic [31:0] ROM_WMASK  = 32'hFFFF_F800;

    typedef enum logic [1:0] {
        KIND_NONE  = 2'd0,
        KIND_IO    = 2'd1,
        KIND_MEM32 = 2'd2,
        KIND_MEM64 = 2'd3
    } bar_kind_e;

    typedef enum logic [2:0] {
        ROLE_OFF,
        ROLE_IO,
        ROLE_MEM32,
        ROLE_LO64,
        ROLE_HI64
    } bar_role_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_RSVD  = 2'd3
    } acc_size_e;

    // Merge lane data into a register: only lane bits inside wmask are cleared,
    // only lane bits inside emask (a subset of wmask) take new data.
    function automatic logic [31:0] merge_write(
        input logic [31:0] cur,
        input logic [31:0] wmask,
        input logic [31:0] emask,
        input logic [31:0] lmask,
        input logic [31:0] ldata
    );
        return (cur & ~(lmask & wmask)) | (ldata & lmask & emask);
    endfunction

endpackage

// File: rtl/pcfg_lane_sel.sv
// Lane selector: turns an access size, byte offset and right-justified data
// into a 32-bit lane mask and lane-aligned data. Flags illegal accesses
// (odd word offset, unaligned dword, reserved size) so they write nothing.
module pcfg_lane_sel
    import pcfg_pkg::*;
(
    input  logic [1:0]  acc_size,
    input  logic [1:0]  acc_off,
    input  logic [31:0] acc_data,
    output logic        lane_ok,
    output logic        is_dword,
    output logic [31:0] lane_mask,
    output logic [31:0] lane_data
);

    logic [4:0] byte_shift;
    logic [4:0] word_shift;

    assign byte_shift = {acc_off, 3'b000};
    assign word_shift = {acc_off[1], 4'b0000};

    // Decode the access into mask and aligned data.
    always_comb begin
        lane_ok   = 1'b0;
        is_dword  = 1'b0;
        lane_mask = '0;
        lane_data = '0;
        case (acc_size_e'(acc_size))
            SZ_BYTE: begin
                lane_ok   = 1'b1;
                lane_mask = 32'h0000_00FF << byte_shift;
                lane_data = {24'h0, acc_data[7:0]} << byte_shift;
            end
            SZ_WORD: begin
                lane_ok = !acc_off[0];
                if (lane_ok) begin
                    lane_mask = 32'h0000_FFFF << word_shift;
                    lane_data = {16'h0, acc_data[15:0]} << word_shift;
                end
            end
            SZ_DWORD: begin
                lane_ok  = (acc_off == 2'd0);
                is_dword = lane_ok;
                if (lane_ok) begin
                    lane_mask = '1;
                    lane_data = acc_data;
                end
            end
            default: begin
                lane_ok = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcfg_bar_slot.sv
// One base address register slot. The role (absent, I/O, 32-bit memory,
// lower or upper half of 64-bit memory) sets the writable mask, the read-only
// type bits and the size pattern. An all-ones dword write narrows the mask to
// the size pattern. Assumes role and size stay static after reset.
module pcfg_bar_slot
    import pcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  bar_role_e   role,
    input  logic        pref,
    input  logic [5:0]  size_log2,
    input  logic        sel,
    input  logic        is_dword,
    input  logic [31:0] raw_data,
    input  logic [31:0] lane_mask,
    input  logic [31:0] lane_data,
    output logic [31:0] value
);

    logic [63:0] enc64;
    logic [31:0] enc32;
    logic [31:0] wmask;
    logic [31:0] ro_bits;
    logic [31:0] size_pat;
    logic [31:0] eff_mask;
    logic        probe;

    assign enc64 = {64{1'b1}} << size_log2;
    assign enc32 = 32'hFFFF_FFFF << size_log2;

    // Role decode into mask, type bits and size pattern.
    always_comb begin
        wmask    = '0;
        ro_bits  = '0;
        size_pat = '0;
        case (role)
            ROLE_IO: begin
                wmask    = 32'hFFFF_FFFC;
                ro_bits  = 32'h0000_0001;
                size_pat = enc32;
            end
            ROLE_MEM32: begin
                wmask    = 32'hFFFF_FFF0;
                ro_bits  = {28'h0, pref, 3'b000};
                size_pat = enc32;
            end
            ROLE_LO64: begin
                wmask    = 32'hFFFF_FFF0;
                ro_bits  = {28'h0, pref, 3'b100};
                size_pat = enc64[31:0];
            end
            ROLE_HI64: begin
                wmask    = 32'hFFFF_FFFF;
                size_pat = enc64[63:32];
            end
            default: begin
                wmask = '0;
            end
        endcase
    end

    assign probe    = is_dword && (raw_data == 32'hFFFF_FFFF);
    assign eff_mask = probe ? (wmask & size_pat) : wmask;

    // Register update: reset to the type bits, then merge writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= ro_bits;
        end else if (sel) begin
            value <= merge_write(value, wmask, eff_mask, lane_mask, lane_data);
        end
    end

endmodule

// File: rtl/pcfg_rom_slot.sv
// Expansion-ROM base register. Writable above bit 10 when present; a dword
// write with bits 31:11 all ones narrows the mask to the ROM size pattern.
module pcfg_rom_slot
    import pcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rom_en,
    input  logic [4:0]  size_log2,
    input  logic        sel,
    input  logic        is_dword,
    input  logic [31:0] raw_data,
    input  logic [31:0] lane_mask,
    input  logic [31:0] lane_data,
    output logic [31:0] value
);

    logic [31:0] wmask;
    logic [31:0] size_pat;
    logic [31:0] eff_mask;
    logic        probe;

    assign wmask    = rom_en ? ROM_WMASK : 32'h0;
    assign size_pat = 32'hFFFF_FFFF << size_log2;
    assign probe    = is_dword && (&raw_data[31:11]);
    assign eff_mask = probe ? (wmask & size_pat) : wmask;

    // Register update: clear at reset, merge writes afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (sel) begin
            value <= merge_write(value, wmask, eff_mask, lane_mask, lane_data);
        end
    end

endmodule

// File: rtl/pcfg_space.sv
// Endpoint configuration register space: sparse decode of NUM_REGS dwords.
// Identity words are captured during reset; command, cache-line, interrupt,
// base address and ROM registers merge writes through writable masks.
// Assumes configuration inputs (slot kinds, sizes, ROM) are static.
module pcfg_space
    import pcfg_pkg::*;
#(
    parameter int unsigned NUM_REGS = 1024,
    parameter int unsigned NUM_BARS = 6,
    parameter int unsigned IDX_W    = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [15:0]           id_vendor,
    input  logic [15:0]           id_device,
    input  logic [7:0]            id_revision,
    input  logic [7:0]            id_progif,
    input  logic [7:0]            id_subclass,
    input  logic [7:0]            id_class,
    input  logic [15:0]           id_subsys_vendor,
    input  logic [15:0]           id_subsys,
    input  logic [2*NUM_BARS-1:0] bar_kind,
    input  logic [NUM_BARS-1:0]   bar_pref,
    input  logic [6*NUM_BARS-1:0] bar_size_log2,
    input  logic                  rom_en,
    input  logic [4:0]            rom_size_log2,
    input  logic                  irq_set,
    input  logic [7:0]            irq_line,
    input  logic [1:0]            irq_pin,
    input  logic                  wr_en,
    input  logic [1:0]            wr_size,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [1:0]            wr_off,
    input  logic [31:0]           wr_data,
    input  logic [IDX_W-1:0]      rd_idx,
    output logic [31:0]           rd_data
);

    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_REGS);

    logic        lane_ok;
    logic        is_dword;
    logic [31:0] lane_mask;
    logic [31:0] lane_data;
    logic        wr_go;

    logic [31:0] id_q;
    logic [31:0] class_q;
    logic [31:0] subsys_q;
    logic [31:0] cmd_q;
    logic [31:0] misc_q;
    logic [31:0] irq_q;
    logic [31:0] rom_q;

    bar_role_e   roles     [NUM_BARS];
    logic [5:0]  slot_size [NUM_BARS];
    logic [31:0] bar_val   [NUM_BARS];
    logic [NUM_BARS*32-1:0] bar_flat;

    pcfg_lane_sel u_lane (
        .acc_size  (wr_size),
        .acc_off   (wr_off),
        .acc_data  (wr_data),
        .lane_ok   (lane_ok),
        .is_dword  (is_dword),
        .lane_mask (lane_mask),
        .lane_data (lane_data)
    );

    assign wr_go = wr_en && lane_ok && (wr_idx < LIMIT);

    // Slot roles: a 64-bit slot claims its successor as upper half.
    always_comb begin
        logic claim;
        claim = 1'b0;
        for (int i = 0; i < NUM_BARS; i++) begin
            slot_size[i] = bar_size_log2[6*i +: 6];
            if (claim) begin
                roles[i]     = ROLE_HI64;
                slot_size[i] = bar_size_log2[6*(i-1) +: 6];
                claim        = 1'b0;
            end else begin
                case (bar_kind_e'(bar_kind[2*i +: 2]))
                    KIND_IO:    roles[i] = ROLE_IO;
                    KIND_MEM32: roles[i] = ROLE_MEM32;
                    KIND_MEM64: begin
                        if (i == NUM_BARS - 1) begin
                            roles[i] = ROLE_OFF;
                        end else begin
                            roles[i] = ROLE_LO64;
                            claim    = 1'b1;
                        end
                    end
                    default:    roles[i] = ROLE_OFF;
                endcase
            end
        end
    end

    for (genvar g = 0; g < NUM_BARS; g++) begin : g_bar
        pcfg_bar_slot u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .role      (roles[g]),
            .pref      (bar_pref[g]),
            .size_log2 (slot_size[g]),
            .sel       (wr_go && (wr_idx == IDX_W'(IDX_BAR0 + g))),
            .is_dword  (is_dword),
            .raw_data  (wr_data),
            .lane_mask (lane_mask),
            .lane_data (lane_data),
            .value     (bar_val[g])
        );
        assign bar_flat[32*g +: 32] = bar_val[g];
    end

    pcfg_rom_slot u_rom (
        .clk       (clk),
        .rst_n     (rst_n),
        .rom_en    (rom_en),
        .size_log2 (rom_size_log2),
        .sel       (wr_go && (wr_idx == IDX_W'(IDX_ROM))),
        .is_dword  (is_dword),
        .raw_data  (wr_data),
        .lane_mask (lane_mask),
        .lane_data (lane_data),
        .value     (rom_q)
    );

    // Identity words: captured while reset is held, read-only afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q     <= {id_device, id_vendor};
            class_q  <= {id_class, id_subclass, id_progif, id_revision};
            subsys_q <= {id_subsys, id_subsys_vendor};
        end
    end

    // Command and cache-line registers: masked writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= '0;
            misc_q <= '0;
        end else if (wr_go) begin
            if (wr_idx == IDX_W'(IDX_CMD))
                cmd_q <= merge_write(cmd_q, CMD_WMASK, CMD_WMASK, lane_mask, lane_data);
            if (wr_idx == IDX_W'(IDX_MISC))
                misc_q <= merge_write(misc_q, BYTE_WMASK, BYTE_WMASK, lane_mask, lane_data);
        end
    end

    // Interrupt word: platform install wins over a bus write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else if (irq_set) begin
            irq_q <= {irq_q[31:16], {6'h0, irq_pin} + 8'd1, irq_line};
        end else if (wr_go && (wr_idx == IDX_W'(IDX_IRQ))) begin
            irq_q <= merge_write(irq_q, BYTE_WMASK, BYTE_WMASK, lane_mask, lane_data);
        end
    end

    // Read mux: all ones outside the space, zero for unbacked indices.
    always_comb begin
        rd_data = '0;
        if (rd_idx >= LIMIT) begin
            rd_data = '1;
        end else begin
            if (rd_idx == IDX_W'(IDX_IDENT))  rd_data = id_q;
            if (rd_idx == IDX_W'(IDX_CMD))    rd_data = cmd_q;
            if (rd_idx == IDX_W'(IDX_CLASS))  rd_data = class_q;
            if (rd_idx == IDX_W'(IDX_MISC))   rd_data = misc_q;
            if (rd_idx == IDX_W'(IDX_SUBSYS)) rd_data = subsys_q;
            if (rd_idx == IDX_W'(IDX_ROM))    rd_data = rom_q;
            if (rd_idx == IDX_W'(IDX_IRQ))    rd_data = irq_q;
            for (int i = 0; i < NUM_BARS; i++) begin
                if (rd_idx == IDX_W'(IDX_BAR0 + i)) rd_data = bar_val[i];
            end
        end
    end

endmodule

// File: rtl/pcfg_space_chk.sv
// Property checker for pcfg_space, attached with bind below.
module pcfg_space_chk #(
    parameter int unsigned NUM_REGS = 1024,
    parameter int unsigned NUM_BARS = 6,
    parameter int unsigned IDX_W    = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic [1:0]             wr_size,
    input logic [1:0]             wr_off,
    input logic [IDX_W-1:0]       wr_idx,
    input logic                   irq_set,
    input logic [1:0]             irq_pin,
    input logic [IDX_W-1:0]       rd_idx,
    input logic [31:0]            rd_data,
    input logic [31:0]            id_word,
    input logic [31:0]            cmd_word,
    input logic [31:0]            misc_word,
    input logic [31:0]            irq_word,
    input logic [31:0]            rom_word,
    input logic [NUM_BARS*32-1:0] bar_flat
);

    localparam logic [IDX_W-1:0] LIMIT = IDX_W'(NUM_REGS);

    logic [NUM_BARS*32+127:0] all_state;
    assign all_state = {bar_flat, cmd_word, misc_word, irq_word, rom_word};

    // R1: reads beyond the space return all ones
    p_oob_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx >= LIMIT) |-> (rd_data == 32'hFFFF_FFFF));

    // R1: writes beyond the space leave every register untouched
    p_oob_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_idx >= LIMIT) && !irq_set) |=> $stable(all_state));

    // R2: identity word holds after reset
    p_ident_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(id_word));

    // R3: status half of the command word never changes
    p_status_ro_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cmd_word[31:16]));

    // R4: type bits of the first slot are read-only
    p_bar_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(bar_flat[1:0]));

    // R8: odd-offset word writes change nothing
    p_bad_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_size == 2'd1) && wr_off[0] && !irq_set) |=> $stable(all_state));

    // R10: installed pin field is one-based and upper half is kept
    p_irq_pin_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set |=> ((irq_word[15:8] == ({6'h0, $past(irq_pin)} + 8'd1))
                     && (irq_word[31:16] == $past(irq_word[31:16]))));

endmodule

bind pcfg_space pcfg_space_chk #(
    .NUM_REGS (NUM_REGS),
    .NUM_BARS (NUM_BARS),
    .IDX_W    (IDX_W)
) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_size   (wr_size),
    .wr_off    (wr_off),
    .wr_idx    (wr_idx),
    .irq_set   (irq_set),
    .irq_pin   (irq_pin),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .id_word   (id_q),
    .cmd_word  (cmd_q),
    .misc_word (misc_q),
    .irq_word  (irq_q),
    .rom_word  (rom_q),
    .bar_flat  (bar_flat)
);

// File: tb/test_pcfg_space.sv
// Directed bench for pcfg_space: one task per scenario, each self-checking.
module test_pcfg_space;

    localparam int NB = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [15:0]   id_vendor = 16'h1234;
    logic [15:0]   id_device = 16'h5678;
    logic [7:0]    id_revision = 8'h01;
    logic [7:0]    id_progif = 8'h5A;
    logic [7:0]    id_subclass = 8'h01;
    logic [7:0]    id_class = 8'h04;
    logic [15:0]   id_subsys_vendor = 16'hABCD;
    logic [15:0]   id_subsys = 16'h2468;
    logic [2*NB-1:0] bar_kind;
    logic [NB-1:0] bar_pref;
    logic [6*NB-1:0] bar_size_log2;
    logic          rom_en = 1'b1;
    logic [4:0]    rom_size_log2 = 5'd16;
    logic          irq_set = 1'b0;
    logic [7:0]    irq_line = 8'h0;
    logic [1:0]    irq_pin = 2'd0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_size = 2'd2;
    logic [11:0]   wr_idx = '0;
    logic [1:0]    wr_off = 2'd0;
    logic [31:0]   wr_data = '0;
    logic [11:0]   rd_idx = '0;
    logic [31:0]   rd_data;

    int n_vec = 0;
    int n_bad = 0;

    // Slots: 0 mem32 4KiB, 1 I/O 32B, 2 mem64 prefetchable 8GiB, 3 declared
    // mem32 but claimed as upper half, 4 none, 5 mem64 with no partner.
    assign bar_kind      = {2'd3, 2'd0, 2'd2, 2'd3, 2'd1, 2'd2};
    assign bar_pref      = 6'b000100;
    assign bar_size_log2 = {6'd20, 6'd0, 6'd0, 6'd33, 6'd5, 6'd12};

    always #2 clk = ~clk;

    pcfg_space i_pcfg_space (
        .clk(clk), .rst_n(rst_n),
        .id_vendor(id_vendor), .id_device(id_device), .id_revision(id_revision),
        .id_progif(id_progif), .id_subclass(id_subclass), .id_class(id_class),
        .id_subsys_vendor(id_subsys_vendor), .id_subsys(id_subsys),
        .bar_kind(bar_kind), .bar_pref(bar_pref), .bar_size_log2(bar_size_log2),
        .rom_en(rom_en), .rom_size_log2(rom_size_log2),
        .irq_set(irq_set), .irq_line(irq_line), .irq_pin(irq_pin),
        .wr_en(wr_en), .wr_size(wr_size), .wr_idx(wr_idx), .wr_off(wr_off),
        .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data)
    );

    task automatic expect_reg(input string tag, input logic [11:0] idx, input logic [31:0] exp);
        @(negedge clk);
        rd_idx = idx;
        #1;
        n_vec++;
        if (rd_data !== exp) begin
            n_bad++;
            $display("FAIL %s idx=%0d got=%h exp=%h", tag, idx, rd_data, exp);
        end
    endtask

    task automatic put(input logic [11:0] idx, input logic [1:0] off,
                       input logic [1:0] sz, input logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_off = off; wr_size = sz; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        expect_reg("R3 reset cmd", 1, 32'h0);
        expect_reg("R3 reset misc", 3, 32'h0);
        expect_reg("R3 reset irq", 15, 32'h0);
        expect_reg("R4 reset bar0", 4, 32'h0);
        expect_reg("R4 reset bar1 io", 5, 32'h1);
        expect_reg("R6 reset bar2 lo", 6, 32'hC);
        expect_reg("R6 reset bar3 hi", 7, 32'h0);
        expect_reg("R7 reset rom", 12, 32'h0);
    endtask

    task automatic t_identity;
        id_vendor = 16'h0000;
        expect_reg("R2 ident", 0, 32'h5678_1234);
        expect_reg("R2 class", 2, 32'h0401_5A01);
        expect_reg("R2 subsys", 11, 32'h2468_ABCD);
        put(0, 0, 2, 32'hFFFF_FFFF);
        expect_reg("R2 ident read-only", 0, 32'h5678_1234);
    endtask

    task automatic t_masks;
        put(1, 0, 2, 32'hFFFF_FFFF);
        expect_reg("R3 cmd mask", 1, 32'h0000_FFFF);
        put(3, 0, 2, 32'hFFFF_FFFF);
        expect_reg("R3 misc mask", 3, 32'h0000_00FF);
        put(15, 0, 2, 32'hFFFF_FFFF);
        expect_reg("R3 irq mask", 15, 32'h0000_00FF);
    endtask

    task automatic t_timing;
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3; wr_off = 0; wr_size = 2; wr_data = 32'h11;
        rd_idx = 3;
        #1;
        n_vec++;
        if (rd_data !== 32'hFF) begin
            n_bad++;
            $display("FAIL R11 before edge got=%h exp=%h", rd_data, 32'hFF);
        end
        @(negedge clk);
        wr_en = 1'b0;
        expect_reg("R11 after edge", 3, 32'h11);
    endtask

    task automatic t_bar32;
        put(4, 0, 2, 32'hFFFF_FFFF);
        expect_reg("R5 mem32 probe", 4, 32'hFFFF_F000);
        put(4, 0, 2, 32'h1234_5678);
        expect_reg("R5 mem32 addr", 4, 32'h1234_5670);
        put(5, 0, 2, 32'hFFFF_FFFF);
        expect_reg("R5 io probe", 5, 32'hFFFF_FFE1);
        put(5, 0, 2, 32'h0000_ABCE);
        expect_reg("R4 io addr", 5, 32'h0000_ABCD);
    endtask

    task automatic t_bar64;
        put(6, 0, 2, 32'hFFFF_FFFF);
        expect_reg("R6 lo probe", 6, 32'h0000_000C);
        put(7, 0, 2, 32'hFFFF_FFFF);
        expect_reg("R6 hi probe", 7, 32'hFFFF_FFFE);
        put(7, 0, 2, 32'h0000_0001);
        expect_reg("R6 hi addr", 7, 32'h0000_0001);
        put(6, 0, 2, 32'h8000_0000);
        expect_reg("R6 lo addr", 6, 32'h8000_000C);
        put(8, 0, 2, 32'hFFFF_FFFF);
        expect_reg("R4 none slot", 8, 32'h0);
        put(9, 0, 2, 32'h1234_5678);
        expect_reg("R6 last mem64 absent", 9, 32'h0);
    endtask

    task automatic t_rom;
        put(12, 0, 2, 32'h00AB_C123);
        expect_reg("R7 rom addr", 12, 32'h00AB_C000);
        put(12, 0, 2, 32'hFFFF_F801);
        expect_reg("R7 rom probe", 12, 32'hFFFF_0000);
        put(12, 1, 0, 32'h0000_00FF);
        expect_reg("R9 rom byte no probe", 12, 32'hFFFF_F800);
    endtask

    task automatic t_offsets;
        put(1, 0, 2, 32'h0);
        put(1, 0, 1, 32'h0000_A5A5);
        expect_reg("R8 word off0", 1, 32'h0000_A5A5);
        put(1, 1, 1, 32'h0000_FFFF);
        expect_reg("R8 word off1 ignored", 1, 32'h0000_A5A5);
        put(1, 3, 1, 32'h0000_0000);
        expect_reg("R8 word off3 ignored", 1, 32'h0000_A5A5);
        put(1, 1, 2, 32'hFFFF_FFFF);
        expect_reg("R8 dword off1 ignored", 1, 32'h0000_A5A5);
        put(1, 0, 3, 32'h0);
        expect_reg("R8 reserved size ignored", 1, 32'h0000_A5A5);
        put(1, 2, 1, 32'h0000_1234);
        expect_reg("R3 word into status", 1, 32'h0000_A5A5);
    endtask

    task automatic t_lanes;
        put(1, 1, 0, 32'h0);
        expect_reg("R9 byte lane1", 1, 32'h0000_00A5);
        put(1, 0, 0, 32'hFFFF_FF5A);
        expect_reg("R9 byte lane0", 1, 32'h0000_005A);
        put(4, 1, 0, 32'h0000_00AB);
        expect_reg("R9 bar byte lane1", 4, 32'h1234_AB70);
        put(4, 2, 1, 32'h0000_BEEF);
        expect_reg("R9 bar word upper", 4, 32'hBEEF_AB70);
        put(4, 0, 0, 32'h0000_00FF);
        expect_reg("R9 bar type bits kept", 4, 32'hBEEF_ABF0);
        put(4, 3, 0, 32'h0000_00FF);
        expect_reg("R9 byte ones no probe", 4, 32'hFFEF_ABF0);
    endtask

    task automatic t_irq;
        put(15, 0, 2, 32'h0);
        @(negedge clk);
        irq_set = 1'b1; irq_pin = 2'd0; irq_line = 8'h0B;
        @(negedge clk);
        irq_set = 1'b0;
        expect_reg("R10 install", 15, 32'h0000_010B);
        put(15, 0, 0, 32'h22);
        expect_reg("R10 line byte", 15, 32'h0000_0122);
        put(15, 1, 0, 32'h33);
        expect_reg("R10 pin read-only", 15, 32'h0000_0122);
        @(negedge clk);
        irq_set = 1'b1; irq_pin = 2'd2; irq_line = 8'h44;
        wr_en = 1'b1; wr_idx = 15; wr_off = 0; wr_size = 0; wr_data = 32'h77;
        @(negedge clk);
        irq_set = 1'b0; wr_en = 1'b0;
        expect_reg("R10 priority", 15, 32'h0000_0344);
        @(negedge clk);
        irq_set = 1'b1; irq_pin = 2'd3; irq_line = 8'hFF;
        @(negedge clk);
        irq_set = 1'b0;
        expect_reg("R10 pin D", 15, 32'h0000_04FF);
    endtask

    task automatic t_range;
        put(1, 0, 2, 32'h0000_FFFF);
        put(12'd1025, 0, 2, 32'h0);
        expect_reg("R1 oob write no alias", 1, 32'h0000_FFFF);
        expect_reg("R1 oob read 1024", 12'd1024, 32'hFFFF_FFFF);
        expect_reg("R1 oob read 4095", 12'd4095, 32'hFFFF_FFFF);
        put(100, 0, 2, 32'hDEAD_BEEF);
        expect_reg("R1 unbacked index", 100, 32'h0);
        expect_reg("R1 unbacked 13", 13, 32'h0);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_identity();
        t_masks();
        t_timing();
        t_bar32();
        t_bar64();
        t_rom();
        t_offsets();
        t_lanes();
        t_irq();
        t_range();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule